// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This unit lets any of N cores raise an interrupt on any other core through a single shared command port. Each cycle, at most one command arrives. A command carries the issuing core number, a 2-bit operation code and a parameter. Results come back through a separate readback register, one cycle later.

Inside the unit is a sender-by-target pending matrix. Each target core has one interrupt line. That line is the OR of every pending bit aimed at the target, so interrupts from several senders merge into one asserted line. The target asks which senders are pending, gets a one-hot-per-core bitmask back, and acknowledges each sender on its own. The line drops only after the last sender bit is cleared. Software can also poll whether a target already has an interrupt waiting before it raises another. Arbitration between cores for the command port is handled outside this block.

Top module: `icsu`

## Requirements
- R1: While the reset input is low, and after its release, every interrupt line is 0 and the readback word is 0.
- R2: Operation codes are: 0 = raise, 1 = peek target status, 2 = who-sent query, 3 = clear one sender. A raise from core c with parameter t (t < N, t != c) sets the pending bit (sender c, target t). Interrupt line t is high in the cycle after the command edge.
- R3: A raise whose parameter equals the issuing core changes no pending bit and no interrupt line.
- R4: A parameter of N or more has no effect. A raise or clear with such a parameter changes no pending bit, and a peek with it returns 0. The parameter's upper bits are not dropped.
- R5: A peek with parameter t loads the readback with 1 when target t has any pending sender, and with 0 otherwise. The value is visible the cycle after the command edge.
- R6: A who-sent query loads the readback with a bitmask of senders pending toward the issuing core. Bit s stands for sender s, and several bits may be set together.
- R7: A clear issued by core c with parameter s clears only the pending bit (sender s, target c). Other senders toward c stay pending, and c's line stays high while any remain.
- R8: Interrupt line t is the OR of all pending bits toward t. Repeated raises from the same sender merge into one pending bit, and one clear removes it.
- R9: The readback register keeps its value across raise and clear commands and across idle cycles.
- R10: While cmd_valid is low, the operation, core and parameter inputs have no effect on the pending state or on the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_core | input | $clog2(NUM_CORES) | Number of the issuing core |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_param | input | PARAM_W | Target core or sender index |
| rdata | output | DATA_W | Readback register |
| irq_o | output | NUM_CORES | One interrupt line per target core |

## Verification
The pending matrix cannot be seen directly. A wrong bit shows up on the target's interrupt line in the cycle after the command edge. It also shows up in the readback one cycle after a who-sent query from that target or a peek aimed at it. A clear that hits the wrong cell shows at once: either a line stays high with no sender reported, or a still-pending sender vanishes from the who-sent mask. An aliased out-of-range parameter raises a line that should stay low, one cycle after the command.

// File: rtl/icsu_pkg.sv
package icsu_pkg;

  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_PEEK  = 2'd1,
    OP_WHO   = 2'd2,
    OP_CLEAR = 2'd3
  } icsu_op_e;

endpackage

// File: rtl/icsu_rst_sync.sv
module icsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/icsu_decode.sv
module icsu_decode
  import icsu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PARAM_W   = 8,
  localparam int ID_W     = $clog2(NUM_CORES),
  localparam int CELLS    = NUM_CORES * NUM_CORES
) (
  input  logic               cmd_valid,
  input  logic [ID_W-1:0]    cmd_core,
  input  logic [1:0]         cmd_op,
  input  logic [PARAM_W-1:0] cmd_param,
  output logic [CELLS-1:0]   set_vec,
  output logic [CELLS-1:0]   clr_vec
);

  icsu_op_e       op;
  logic           param_ok;
  logic           core_ok;
  logic           do_raise;
  logic           do_clear;
  logic [ID_W-1:0] sel;

  always_comb begin
    op       = icsu_op_e'(cmd_op);
    param_ok = cmd_param < PARAM_W'(NUM_CORES);
    core_ok  = {1'b0, cmd_core} < (ID_W+1)'(NUM_CORES);
    sel      = cmd_param[ID_W-1:0];
    do_raise = cmd_valid && param_ok && core_ok && (op == OP_RAISE);
    do_clear = cmd_valid && param_ok && core_ok && (op == OP_CLEAR);
  end

  // cell index = sender * NUM_CORES + target
  for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
      if (s == t) begin : g_diag
        assign set_vec[s*NUM_CORES+t] = 1'b0;
        assign clr_vec[s*NUM_CORES+t] = 1'b0;
      end else begin : g_cell
        assign set_vec[s*NUM_CORES+t] = do_raise && (cmd_core == ID_W'(s)) && (sel == ID_W'(t));
        assign clr_vec[s*NUM_CORES+t] = do_clear && (cmd_core == ID_W'(t)) && (sel == ID_W'(s));
      end
    end
  end

endmodule

// File: rtl/icsu_matrix.sv
module icsu_matrix #(
  parameter int NUM_CORES = 4,
  localparam int CELLS    = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CELLS-1:0]     set_vec,
  input  logic [CELLS-1:0]     clr_vec,
  output logic [CELLS-1:0]     pend,
  output logic [NUM_CORES-1:0] line
);

  for (genvar c = 0; c < CELLS; c++) begin : g_bit
    logic bit_en;
    logic bit_d;
    logic bit_q;

    always_comb begin
      bit_en = set_vec[c] | clr_vec[c];
      bit_d  = set_vec[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign pend[c] = bit_q;
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
    logic [NUM_CORES-1:0] col;
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_col
      assign col[s] = pend[s*NUM_CORES+t];
    end
    assign line[t] = |col;
  end

endmodule

// File: rtl/icsu_readback.sv
module icsu_readback
  import icsu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PARAM_W   = 8,
  parameter int DATA_W    = 32,
  localparam int ID_W     = $clog2(NUM_CORES),
  localparam int CELLS    = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [ID_W-1:0]      cmd_core,
  input  logic [1:0]           cmd_op,
  input  logic [PARAM_W-1:0]   cmd_param,
  input  logic [CELLS-1:0]     pend,
  input  logic [NUM_CORES-1:0] line,
  output logic [DATA_W-1:0]    rdata
);

  logic [NUM_CORES-1:0] col [NUM_CORES];
  logic [DATA_W-1:0]    rd_d;
  logic                 rd_en;
  logic [DATA_W-1:0]    rd_q;
  icsu_op_e             op;
  logic                 param_ok;
  logic                 core_ok;

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_t
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_s
      assign col[t][s] = pend[s*NUM_CORES+t];
    end
  end

  always_comb begin
    op       = icsu_op_e'(cmd_op);
    param_ok = cmd_param < PARAM_W'(NUM_CORES);
    core_ok  = {1'b0, cmd_core} < (ID_W+1)'(NUM_CORES);
    rd_en    = cmd_valid && ((op == OP_PEEK) || (op == OP_WHO));
    rd_d     = '0;
    if (op == OP_PEEK) begin
      if (param_ok) rd_d = DATA_W'(line[cmd_param[ID_W-1:0]]);
    end else if (core_ok) begin
      rd_d = DATA_W'(col[cmd_core]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/icsu.sv
module icsu #(
  parameter int NUM_CORES = 4,
  parameter int PARAM_W   = 8,
  parameter int DATA_W    = 32,
  localparam int ID_W     = $clog2(NUM_CORES),
  localparam int CELLS    = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [ID_W-1:0]      cmd_core,
  input  logic [1:0]           cmd_op,
  input  logic [PARAM_W-1:0]   cmd_param,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_CORES-1:0] irq_o
);

  logic             rst_q_n;
  logic [CELLS-1:0] set_vec;
  logic [CELLS-1:0] clr_vec;
  logic [CELLS-1:0] pend;

  icsu_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  icsu_decode #(.NUM_CORES(NUM_CORES), .PARAM_W(PARAM_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_core  (cmd_core),
    .cmd_op    (cmd_op),
    .cmd_param (cmd_param),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec)
  );

  icsu_matrix #(.NUM_CORES(NUM_CORES)) u_mat (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend),
    .line    (irq_o)
  );

  icsu_readback #(.NUM_CORES(NUM_CORES), .PARAM_W(PARAM_W), .DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cmd_valid (cmd_valid),
    .cmd_core  (cmd_core),
    .cmd_op    (cmd_op),
    .cmd_param (cmd_param),
    .pend      (pend),
    .line      (irq_o),
    .rdata     (rdata)
  );

endmodule

// File: rtl/icsu_checker.sv
module icsu_checker #(
  parameter int NUM_CORES = 4,
  parameter int PARAM_W   = 8,
  parameter int DATA_W    = 32,
  localparam int ID_W     = $clog2(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 cmd_valid,
  input logic [ID_W-1:0]      cmd_core,
  input logic [1:0]           cmd_op,
  input logic [PARAM_W-1:0]   cmd_param,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_CORES-1:0] irq_o
);

  always @(posedge clk) begin
    if (!rst_q_n) begin
      p_reset_quiet_r1: assert (irq_o == '0 && rdata == '0);
    end
  end

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cmd_valid |=> ($stable(irq_o) && $stable(rdata)));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd3)) |=> $stable(rdata));

  p_peek_range_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_param >= PARAM_W'(NUM_CORES)) |=> (rdata == '0));

  p_raise_range_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 2'd0 && cmd_param >= PARAM_W'(NUM_CORES)) |=> $stable(irq_o));

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_chk
    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cmd_valid && cmd_op == 2'd0 && cmd_param == PARAM_W'(t) && cmd_core != ID_W'(t))
      |=> irq_o[t]);

    p_self_noop_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cmd_valid && cmd_op == 2'd0 && cmd_param == PARAM_W'(t) && cmd_core == ID_W'(t))
      |=> $stable(irq_o));

    p_peek_value_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cmd_valid && cmd_op == 2'd1 && cmd_param == PARAM_W'(t))
      |=> (rdata == DATA_W'($past(irq_o[t]))));

    p_who_matches_line_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cmd_valid && cmd_op == 2'd2 && cmd_core == ID_W'(t))
      |=> ((rdata != '0) == $past(irq_o[t])));

    p_clear_other_targets_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cmd_valid && cmd_op == 2'd3 && cmd_core != ID_W'(t))
      |=> $stable(irq_o[t]));
  end

endmodule

bind icsu icsu_checker #(
  .NUM_CORES (NUM_CORES),
  .PARAM_W   (PARAM_W),
  .DATA_W    (DATA_W)
) u_icsu_checker (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .cmd_valid (cmd_valid),
  .cmd_core  (cmd_core),
  .cmd_op    (cmd_op),
  .cmd_param (cmd_param),
  .rdata     (rdata),
  .irq_o     (irq_o)
);

// File: tb/test_icsu.sv
`timescale 1ns/1ps
module test_icsu;

  localparam int N  = 4;
  localparam int PW = 8;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_core;
  logic [1:0]    cmd_op;
  logic [PW-1:0] cmd_param;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq_o;

  int total;
  int bad;
  bit done;

  icsu #(.NUM_CORES(N), .PARAM_W(PW), .DATA_W(DW)) i_icsu (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_core  (cmd_core),
    .cmd_op    (cmd_op),
    .cmd_param (cmd_param),
    .rdata     (rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge with results visible
  task automatic issue(input int core, input int op, input int param);
    cmd_valid = 1'b1;
    cmd_core  = 2'(core);
    cmd_op    = 2'(op);
    cmd_param = PW'(param);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
  endtask

  task automatic t_raise_and_peek;
    issue(0, 0, 2);
    chk("R2 raise 0->2", 32'(irq_o), 32'h4);
    issue(1, 1, 2);
    chk("R5 peek pending target", rdata, 32'h1);
    issue(1, 1, 3);
    chk("R5 peek idle target", rdata, 32'h0);
  endtask

  task automatic t_multi_source;
    issue(1, 0, 2);
    issue(3, 0, 2);
    chk("R8 merged line", 32'(irq_o), 32'h4);
    issue(2, 2, 0);
    chk("R6 who mask 3 senders", rdata, 32'hb);
    issue(2, 3, 1);
    chk("R7 line held after one clear", 32'(irq_o), 32'h4);
    issue(2, 2, 0);
    chk("R7 only sender 1 cleared", rdata, 32'h9);
    issue(2, 3, 0);
    issue(2, 3, 3);
    chk("R7 line drops after last clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_self;
    issue(1, 0, 1);
    chk("R3 self raise no line", 32'(irq_o), 32'h0);
    issue(1, 1, 1);
    chk("R3 self raise not pending", rdata, 32'h0);
  endtask

  task automatic t_range;
    issue(0, 0, 7);
    chk("R4 raise param 7 no alias", 32'(irq_o), 32'h0);
    issue(2, 0, 0);
    chk("R4 setup 2->0", 32'(irq_o), 32'h1);
    issue(0, 3, 6);
    chk("R4 clear param 6 ignored", 32'(irq_o), 32'h1);
    issue(3, 1, 4);
    chk("R4 peek out of range", rdata, 32'h0);
  endtask

  task automatic t_merge;
    issue(3, 0, 0);
    issue(3, 0, 0);
    issue(0, 3, 3);
    issue(0, 2, 0);
    chk("R8 repeat raises merge, one clear", rdata, 32'h4);
    issue(0, 3, 2);
    chk("R8 line low when column empty", 32'(irq_o), 32'h0);
  endtask

  task automatic t_hold;
    issue(0, 0, 1);
    issue(1, 2, 0);
    chk("R6 who single sender", rdata, 32'h1);
    issue(2, 0, 3);
    chk("R9 rdata held over raise", rdata, 32'h1);
    issue(1, 3, 0);
    chk("R9 rdata held over clear", rdata, 32'h1);
    @(negedge clk);
    chk("R9 rdata held idle", rdata, 32'h1);
    chk("R2 line 3 from core 2", 32'(irq_o), 32'h8);
  endtask

  task automatic t_invalid;
    cmd_core  = 2'd0;
    cmd_op    = 2'd0;
    cmd_param = PW'(1);
    cmd_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 invalid raise ignored", 32'(irq_o), 32'h8);
    cmd_core  = 2'd3;
    cmd_op    = 2'd2;
    @(posedge clk);
    @(negedge clk);
    chk("R10 invalid query ignored", rdata, 32'h1);
    issue(3, 2, 0);
    chk("R6 who after invalid", rdata, 32'h4);
  endtask

  initial begin
    total = 0;
    bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_core = '0;
    cmd_op = '0;
    cmd_param = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raise_and_peek();
    t_multi_source();
    t_self();
    t_range();
    t_merge();
    t_hold();
    t_invalid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule